// File: doc/BRIEF.md
# Adaptive Latency Hold Controller

This controller sits beside a bypassing array multiplier and decides, for every operand pair it accepts, whether the product may be taken after one clock or must be held for a second one. It counts the zero bits of the judged operand: the multiplicand for a column-bypass array, the multiplier for a row-bypass array. When that count reaches a threshold, the operation is treated as short. The `hold` output freezes the multiplier's input registers for the extra cycle. `ready` tells the upstream source when a new operand can be taken.

A timing-error detector on the product register reports, in the cycle after a short operation was accepted, whether that operation really finished in time. A reported error makes the controller refuse new work in that cycle and run the same operation again over two held cycles. Errors are also counted over fixed windows of accepted operations. When one window holds more errors than a set limit, the controller treats the multiplier as worn. From then on it applies a stricter threshold until the next reset, so fewer operations are classed as short.

Top module: `lat_hold_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, `ready` is 1 and `hold` is 0.
- R2: While not worn, an accepted operand is classed short exactly when its count of zero bits is at least `N_FAST`; otherwise it is classed long.
- R3: In the cycle after a short operation is accepted, `hold` is 0 and `ready` is 1 unless `err_in` is high, so a new operand may be taken back to back.
- R4: In the cycle after a long operation is accepted, `hold` is 1 and `ready` is 0; in the cycle after that, `hold` is 0 and `ready` is 1.
- R5: If `err_in` is 1 in the cycle after a short acceptance, `ready` is 0 in that same cycle. The next two cycles each show `hold` 1 and `ready` 0. The cycle after them shows `ready` 1.
- R6: Errors are counted per window of `WIN_OPS` accepted operations, and the count restarts at 0 when a window's last operation is accepted.
- R7: The error that takes a window's count above `ERR_LIMIT` sets a sticky worn state. After that, an operand is classed short only when its zero count is at least `N_STRICT`.
- R8: A synchronous reset clears the worn state and the window counts, which brings back the `N_FAST` rule.
- R9: `err_in` has no effect in any cycle other than the one right after a short acceptance: it does not start a re-execution and is not counted.
- R10: `op_valid` is ignored while `ready` is 0; no operation is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand strobe; accepted when `ready` is 1 |
| op_data | input | OP_W | Judged operand (multiplicand or multiplier, by array variant) |
| err_in | input | 1 | Timing-error flag from the product register's detector |
| hold | output | 1 | Freeze the multiplier input registers this cycle |
| ready | output | 1 | A new operand is taken at the next edge if `op_valid` is 1 |

## Verification
The bench builds the controller with an 8-bit operand, thresholds of 4 and 6 zeros, a window of 8 operations and an error limit of 2. With these values, the worn state and the window restart can be reached within a few dozen cycles. Directed sequences put operands exactly on each threshold and one below it. They place exactly the limit number of errors on both sides of a window boundary, and then one error more inside a single window. Random traffic with frequent errors and occasional resets then runs the model through many aging and reset cycles.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  typedef enum logic [2:0] {
    LHC_IDLE,
    LHC_SHORT,
    LHC_LONG,
    LHC_REDO_A,
    LHC_REDO_B
  } lhc_state_e;

  // Short-class decision: enough zero bits means the array bypasses enough cells
  function automatic logic meets_threshold(input int unsigned zeros, input int unsigned thr);
    return zeros >= thr;
  endfunction
endpackage

// File: rtl/lhc_zero_count.sv
module lhc_zero_count #(
  parameter int OP_W = 16,
  localparam int CW  = $clog2(OP_W + 1)
) (
  input  logic [OP_W-1:0] bits,
  output logic [CW-1:0]   zeros
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < OP_W; i++) begin
      zeros = zeros + CW'(!bits[i]);
    end
  end
endmodule

// File: rtl/lhc_wear_mon.sv
module lhc_wear_mon #(
  parameter int WIN_OPS   = 128,
  parameter int ERR_LIMIT = 8,
  localparam int OPW      = $clog2(WIN_OPS),
  localparam int EW       = $clog2(ERR_LIMIT + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic op_acc,
  input  logic err_evt,
  output logic worn
);
  logic [OPW-1:0] ops_q;
  logic [EW-1:0]  errs_q;
  logic           worn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ops_q  <= '0;
      errs_q <= '0;
      worn_q <= 1'b0;
    end else if (err_evt) begin
      if (errs_q == EW'(ERR_LIMIT)) worn_q <= 1'b1;
      if (errs_q <= EW'(ERR_LIMIT)) errs_q <= errs_q + 1'b1;
    end else if (op_acc) begin
      if (ops_q == OPW'(WIN_OPS - 1)) begin
        ops_q  <= '0;
        errs_q <= '0;
      end else begin
        ops_q <= ops_q + 1'b1;
      end
    end
  end

  assign worn = worn_q;
endmodule

// File: rtl/lhc_seq.sv
module lhc_seq
  import lhc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  input  logic fast_pick,
  input  logic err_in,
  output logic ready,
  output logic hold,
  output logic accept,
  output logic err_evt
);
  lhc_state_e st_q, st_d;

  always_comb begin
    ready   = (st_q == LHC_IDLE) || (st_q == LHC_SHORT && !err_in);
    hold    = (st_q == LHC_LONG) || (st_q == LHC_REDO_A) || (st_q == LHC_REDO_B);
    err_evt = (st_q == LHC_SHORT) && err_in;
    accept  = op_valid && ready;
    if (err_evt)                st_d = LHC_REDO_A;
    else if (accept)            st_d = fast_pick ? LHC_SHORT : LHC_LONG;
    else if (st_q == LHC_REDO_A) st_d = LHC_REDO_B;
    else                        st_d = LHC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LHC_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/lat_hold_ctrl.sv
module lat_hold_ctrl
  import lhc_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int N_FAST    = 9,
  parameter int N_STRICT  = 12,
  parameter int WIN_OPS   = 128,
  parameter int ERR_LIMIT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_data,
  input  logic            err_in,
  output logic            hold,
  output logic            ready
);
  localparam int CW = $clog2(OP_W + 1);

  logic [CW-1:0] zeros;
  logic          worn;
  logic          fast_pick;
  logic          accept;
  logic          err_evt;

  lhc_zero_count #(.OP_W(OP_W)) u_zc (
    .bits  (op_data),
    .zeros (zeros)
  );

  assign fast_pick = meets_threshold(int'(zeros), worn ? N_STRICT : N_FAST);

  lhc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .fast_pick (fast_pick),
    .err_in    (err_in),
    .ready     (ready),
    .hold      (hold),
    .accept    (accept),
    .err_evt   (err_evt)
  );

  lhc_wear_mon #(.WIN_OPS(WIN_OPS), .ERR_LIMIT(ERR_LIMIT)) u_wear (
    .clk     (clk),
    .rst     (rst),
    .op_acc  (accept),
    .err_evt (err_evt),
    .worn    (worn)
  );
endmodule

// File: rtl/lhc_checker.sv
module lhc_checker (
  input logic clk,
  input logic rst,
  input logic hold,
  input logic ready,
  input logic accept,
  input logic fast_pick,
  input logic err_evt,
  input logic worn
);
  AST_RESET_READY: assert property (@(posedge clk) rst |=> ready && !hold); // R1
  AST_SHORT_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    accept && fast_pick |=> !hold); // R3
  AST_LONG_ONE_EXTRA: assert property (@(posedge clk) disable iff (rst)
    accept && !fast_pick |=> (hold && !ready) ##1 (!hold && ready)); // R4
  AST_REDO_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> (hold && !ready) ##1 (hold && !ready) ##1 !hold); // R5
  AST_ERR_NOT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> !accept); // R5
  AST_WORN_STICKY: assert property (@(posedge clk) disable iff (rst)
    worn |=> worn); // R7
  AST_RESET_CLEARS_WORN: assert property (@(posedge clk) rst |=> !worn); // R8
  AST_HOLD_NO_ERR_EVT: assert property (@(posedge clk) disable iff (rst)
    hold |-> !err_evt && !ready); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !accept); // R10
endmodule

bind lat_hold_ctrl lhc_checker u_lhc_checker (
  .clk       (clk),
  .rst       (rst),
  .hold      (hold),
  .ready     (ready),
  .accept    (accept),
  .fast_pick (fast_pick),
  .err_evt   (err_evt),
  .worn      (worn)
);

// File: tb/lat_hold_ctrl_bench.sv
`timescale 1ns/1ps
module lat_hold_ctrl_bench;
  localparam int OP_W = 8, N1 = 4, N2 = 6, WIN = 8, LIM = 2;
  localparam int S_IDLE = 0, S_SHORT = 1, S_LONG = 2, S_RA = 3, S_RB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [OP_W-1:0] op_data = '0;
  logic err_in = 1'b0;
  logic hold, ready;

  always #2.5 clk = ~clk;

  lat_hold_ctrl #(.OP_W(OP_W), .N_FAST(N1), .N_STRICT(N2), .WIN_OPS(WIN), .ERR_LIMIT(LIM))
    u_lat_hold_ctrl (.clk(clk), .rst(rst), .op_valid(op_valid), .op_data(op_data),
                     .err_in(err_in), .hold(hold), .ready(ready));

  int n_chk = 0, n_bad = 0;
  int m_st = S_IDLE, m_ops = 0, m_errs = 0;
  bit m_worn = 0;
  string tag = "";
  bit finished = 0;

  function automatic int zeros_in(input logic [OP_W-1:0] v);
    return OP_W - $countones(v);
  endfunction

  function automatic bit exp_ready(input int st, input bit e);
    return (st == S_IDLE) || (st == S_SHORT && !e);
  endfunction

  function automatic bit exp_hold(input int st);
    return st == S_LONG || st == S_RA || st == S_RB;
  endfunction

  function automatic string state_tag(input int st);
    case (st)
      S_SHORT: return "R3";
      S_LONG:  return "R4";
      S_RA, S_RB: return "R5";
      default: return "R2";
    endcase
  endfunction

  // One clock: drive, compare, then advance the model
  task automatic step(input bit v, input logic [OP_W-1:0] d, input bit e, input bit r);
    bit er, eh, acc;
    string t;
    @(posedge clk);
    #1;
    op_valid = v; op_data = d; err_in = e; rst = r;
    #1;
    er = exp_ready(m_st, e);
    eh = exp_hold(m_st);
    t = (tag != "") ? tag : state_tag(m_st);
    n_chk++;
    if (ready !== er || hold !== eh) begin
      n_bad++;
      $display("FAIL %s: ready=%b hold=%b expected ready=%b hold=%b", t, ready, hold, er, eh);
    end
    acc = v && er;
    if (r) begin
      m_st = S_IDLE; m_ops = 0; m_errs = 0; m_worn = 0;
    end else if (m_st == S_SHORT && e) begin
      m_st = S_RA;
      if (m_errs == LIM) m_worn = 1;
      if (m_errs <= LIM) m_errs++;
    end else if (acc) begin
      m_st = (zeros_in(d) >= (m_worn ? N2 : N1)) ? S_SHORT : S_LONG;
      if (m_ops == WIN - 1) begin m_ops = 0; m_errs = 0; end
      else m_ops++;
    end else begin
      m_st = (m_st == S_RA) ? S_RB : S_IDLE;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    // R1: reset state, model already at reset values
    tag = "R1"; step(0, '0, 0, 1); step(0, '0, 0, 0); tag = "";
    // R2, R3: exactly N1 zeros is short, back-to-back N1-1 zeros is long
    tag = "R2"; step(1, 8'hF0, 0, 0); tag = "R3"; step(1, 8'hF8, 0, 0);
    tag = "R4"; idle(3);
    // R10: op_valid during a long hold is ignored
    step(1, 8'hFE, 0, 0); tag = "R10"; step(1, 8'h00, 0, 0); tag = "R4"; idle(2);
    // R9: errors outside the result cycle of a short op do nothing
    tag = "R9"; step(1, 8'hFF, 0, 0); step(0, '0, 1, 0); step(0, '0, 1, 0); idle(2);
    // R5: error after a short op, with a competing operand that must be refused
    tag = "R5"; step(1, 8'h00, 0, 0); step(1, 8'h00, 1, 0); idle(4);
    // R8 then R6: two errors in one window, window wraps, two more, still not worn
    tag = "R8"; step(0, '0, 0, 1); tag = "R6";
    for (int i = 0; i < WIN; i++) begin
      step(1, 8'hF0, 0, 0);
      step(0, '0, (i < LIM), 0);
      idle(3);
    end
    for (int i = 0; i < LIM; i++) begin step(1, 8'hF0, 0, 0); step(0, '0, 1, 0); idle(3); end
    step(1, 8'hF0, 0, 0); idle(2);
    // R7: one error beyond the limit in this window switches to the strict rule
    tag = "R7"; step(1, 8'hF0, 0, 0); step(0, '0, 1, 0); idle(3);
    step(1, 8'hF0, 0, 0); idle(3);
    step(1, 8'hE0, 0, 0); idle(3);
    step(1, 8'hC0, 0, 0); idle(2);
    // R8: reset restores the first rule
    tag = "R8"; step(0, '0, 0, 1); step(1, 8'hF0, 0, 0); idle(2);
    tag = "";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, OP_W'($urandom), ($urandom % 5) == 0, ($urandom % 400) == 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule